// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers twenty request lines (sixteen from pins, four from on-chip units) and presents one interrupt to a processor. Each line has its own configuration word that sets whether it is masked, whether it triggers on an edge or on a level, which edge or level is active, a 4-bit priority and an 8-bit vector. A read-only activity bit shows when the line is waiting or being serviced. Among the pending, unmasked lines the highest priority wins, and the lower line index breaks ties. The winner raises the interrupt output only if its priority is strictly above both the processor's task-priority threshold and the highest priority already in service.

Software takes an interrupt by reading the acknowledge register. The read returns the winning vector and moves that line into service. When nothing qualifies, the read returns the spurious vector 0xFF. A write to the end-of-interrupt register retires the highest-priority line in service. The global configuration register holds a self-clearing reset command and a mode bit.

The register port is a simple single-cycle bus. Word addresses are: global configuration 0, task priority 1, acknowledge 2, end of interrupt 3, and line i at 32+i. Read data is registered.

Top module: `pic_top`

## Requirements
- R1: After rst_ni is released, every line word reads 0x8080_0000 (masked, active-high, edge, priority 0, vector 0), the task priority reads 0xF, int_o is 0 and an acknowledge read returns 0x0000_00FF.
- R2: A line word has the following layout: bit 31 mask (1 = disabled), bit 30 activity (read-only), bit 23 polarity (1 = high/rising, 0 = low/falling), bit 22 sense (1 = level, 0 = edge), bits 19:16 priority and bits 7:0 vector. All other bits read 0, and a write reads back exactly when the line is idle.
- R3: An edge-sense line that is unmasked latches a pending request on its selected edge, and the request stays pending after the input returns. A masked line ignores edges. The request shows on int_o after one clock edge.
- R4: A level-sense line is pending only while its input is at the active level. int_o follows the input one clock edge later.
- R5: int_o is 1 exactly when some unmasked pending line has a priority strictly above the task priority (register bits 3:0) and above the highest priority in service.
- R6: An acknowledge read returns the vector of the qualifying line with the highest priority, with the lower index winning ties, in bits 7:0. It moves that line into service and clears its edge request.
- R7: An acknowledge read returns 0xFF when nothing qualifies. This includes a line that was masked after it requested and a task priority that was raised above the pending request.
- R8: A write to the end-of-interrupt register retires the highest-priority line in service and clears its activity bit. A level line still at its active level then becomes pending again.
- R9: The activity bit is 1 while a line is pending or in service. While it is 1, a write to that line changes only the mask bit.
- R10: Writing bit 31 = 1 to the global configuration register starts a reset. Bit 31 reads 1 for RST_CYCLES cycles and then 0. Afterwards every line is back to its R1 state, nothing is pending or in service, and the task priority is 0xF.
- R11: Bit 29 of the global configuration register stores the mixed-mode selection and reads it back. A reset clears it.
- R12: While a line is in service, only lines of strictly higher priority raise int_o. Lower ones wait until the end-of-interrupt write retires it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after the strobe |
| irq_i | input | N_SRC | Request lines, synchronous to clk_i |
| int_o | output | 1 | Interrupt to the processor |

## Verification
Writes, acknowledge side effects and end-of-interrupt retirement take effect on the clock edge that samples the strobe. int_o reflects them right after that edge. Read data becomes valid one edge after the read strobe. A change on an input line reaches int_o after one edge, because every line is registered once. The bench drives the bus and the lines on the falling edge and samples int_o and the read data on the next falling edge, which is where each result is due. For the reset command it polls bit 31 and bounds the number of reads it allows.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DATA_W = 32;
  localparam int PRI_W  = 4;
  localparam int VEC_W  = 8;

  localparam int ADR_GCR = 0;
  localparam int ADR_TPR = 1;
  localparam int ADR_ACK = 2;
  localparam int ADR_EOI = 3;

  localparam int GCR_RST_BIT = 31;
  localparam int GCR_MIX_BIT = 29;

  localparam logic [VEC_W-1:0] SPUR_VEC = 8'hFF;
  localparam logic [PRI_W-1:0] TPR_RST  = 4'hF;

  typedef struct packed {
    logic             mask;
    logic             pol;
    logic             lvl;
    logic [PRI_W-1:0] pri;
    logic [VEC_W-1:0] vec;
  } src_cfg_t;

  localparam src_cfg_t CFG_RST = '{mask: 1'b1, pol: 1'b1, lvl: 1'b0, pri: '0, vec: '0};
endpackage

// File: rtl/pic_arb.sv
module pic_arb
  import pic_pkg::*;
#(
  parameter int N     = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            vld_i,
  input  logic [N-1:0][PRI_W-1:0] pri_i,
  output logic                    found_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [PRI_W-1:0]        pri_o
);
  // strict compare while scanning upward keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    pri_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (vld_i[i] && (!found_o || pri_i[i] > pri_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        pri_o   = pri_i[i];
      end
    end
  end
endmodule

// File: rtl/pic_src.sv
module pic_src
  import pic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              irq_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  output logic              pend_o,
  output logic              isr_o,
  output logic              mask_o,
  output logic [PRI_W-1:0]  pri_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [DATA_W-1:0] rdata_o
);
  src_cfg_t cfg_q;
  logic     irq_q, epend_q, isr_q, active, edge_hit, lvl_act;

  assign lvl_act  = (irq_q == cfg_q.pol);
  assign edge_hit = !cfg_q.lvl && !cfg_q.mask && (irq_i == cfg_q.pol) && (irq_q != cfg_q.pol);
  assign pend_o   = cfg_q.lvl ? (lvl_act && !isr_q) : epend_q;
  assign active   = pend_o || isr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= CFG_RST;
      epend_q <= 1'b0;
      isr_q   <= 1'b0;
    end else if (soft_rst_i) begin
      cfg_q   <= CFG_RST;
      epend_q <= 1'b0;
      isr_q   <= 1'b0;
    end else begin
      if (wr_i) begin
        cfg_q.mask <= wdata_i[31];
        if (!active) begin
          cfg_q.pol <= wdata_i[23];
          cfg_q.lvl <= wdata_i[22];
          cfg_q.pri <= wdata_i[19:16];
          cfg_q.vec <= wdata_i[7:0];
        end
      end
      epend_q <= edge_hit || (epend_q && !ack_i);
      if (ack_i)      isr_q <= 1'b1;
      else if (eoi_i) isr_q <= 1'b0;
    end
  end

  assign isr_o   = isr_q;
  assign mask_o  = cfg_q.mask;
  assign pri_o   = cfg_q.pri;
  assign vec_o   = cfg_q.vec;
  assign rdata_o = {cfg_q.mask, active, 6'b0, cfg_q.pol, cfg_q.lvl, 2'b0, cfg_q.pri, 8'b0, cfg_q.vec};

  AST_ACK_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !soft_rst_i |=> isr_q); // R6
  AST_CFG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && active && !soft_rst_i |=> $stable(cfg_q.pri) && $stable(cfg_q.vec) && $stable(cfg_q.pol) && $stable(cfg_q.lvl)); // R9
  AST_SOFT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> mask_o && !isr_o && !pend_o); // R10
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int N_SRC      = 20,
  parameter int ADDR_W     = 6,
  parameter int SRC_BASE   = 32,
  parameter int RST_CYCLES = 4,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_SRC-1:0]  irq_i,
  output logic              int_o
);
  logic [N_SRC-1:0]             pend, isr, mask, src_wr, ack_sel, eoi_sel;
  logic [N_SRC-1:0][PRI_W-1:0]  pri;
  logic [N_SRC-1:0][VEC_W-1:0]  vec;
  logic [N_SRC-1:0][DATA_W-1:0] src_rdata;
  logic [CNT_W-1:0]             rst_cnt_q;
  logic [PRI_W-1:0]             tp_q;
  logic                         mix_q, busy, rst_start, qualify;
  logic                         p_found, s_found, ack_rd, eoi_wr;
  logic [IDX_W-1:0]             p_idx, s_idx;
  logic [PRI_W-1:0]             p_pri, s_pri;
  logic [DATA_W-1:0]            rd_mux, rdata_q;

  assign busy      = (rst_cnt_q != '0);
  assign rst_start = bus_wr_i && !busy && bus_addr_i == ADDR_W'(ADR_GCR) && bus_wdata_i[GCR_RST_BIT];
  assign ack_rd    = bus_rd_i && !busy && bus_addr_i == ADDR_W'(ADR_ACK);
  assign eoi_wr    = bus_wr_i && !busy && bus_addr_i == ADDR_W'(ADR_EOI);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign src_wr[g]  = bus_wr_i && !busy && bus_addr_i == ADDR_W'(SRC_BASE + g);
    assign ack_sel[g] = ack_rd && qualify && p_idx == IDX_W'(g);
    assign eoi_sel[g] = eoi_wr && s_found && s_idx == IDX_W'(g);
    pic_src u_src (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (busy),
      .irq_i      (irq_i[g]),
      .wr_i       (src_wr[g]),
      .wdata_i    (bus_wdata_i),
      .ack_i      (ack_sel[g]),
      .eoi_i      (eoi_sel[g]),
      .pend_o     (pend[g]),
      .isr_o      (isr[g]),
      .mask_o     (mask[g]),
      .pri_o      (pri[g]),
      .vec_o      (vec[g]),
      .rdata_o    (src_rdata[g])
    );
  end

  pic_arb #(.N(N_SRC)) u_arb_pend (
    .vld_i (pend & ~mask), .pri_i (pri),
    .found_o (p_found), .idx_o (p_idx), .pri_o (p_pri)
  );
  pic_arb #(.N(N_SRC)) u_arb_isr (
    .vld_i (isr), .pri_i (pri),
    .found_o (s_found), .idx_o (s_idx), .pri_o (s_pri)
  );

  assign qualify = !busy && p_found && (p_pri > tp_q) && (!s_found || p_pri > s_pri);
  assign int_o   = qualify;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_cnt_q <= '0;
      tp_q      <= TPR_RST;
      mix_q     <= 1'b0;
    end else if (rst_start) begin
      rst_cnt_q <= CNT_W'(RST_CYCLES);
      tp_q      <= TPR_RST;
      mix_q     <= 1'b0;
    end else if (busy) begin
      rst_cnt_q <= rst_cnt_q - 1'b1;
      tp_q      <= TPR_RST;
      mix_q     <= 1'b0;
    end else if (bus_wr_i) begin
      if (bus_addr_i == ADDR_W'(ADR_GCR)) mix_q <= bus_wdata_i[GCR_MIX_BIT];
      if (bus_addr_i == ADDR_W'(ADR_TPR)) tp_q  <= bus_wdata_i[PRI_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr_i == ADDR_W'(ADR_GCR)) begin
      rd_mux[GCR_RST_BIT] = busy;
      rd_mux[GCR_MIX_BIT] = mix_q;
    end else if (bus_addr_i == ADDR_W'(ADR_TPR)) begin
      rd_mux[PRI_W-1:0] = tp_q;
    end else if (bus_addr_i == ADDR_W'(ADR_ACK)) begin
      rd_mux[VEC_W-1:0] = qualify ? vec[p_idx] : SPUR_VEC;
    end else begin
      for (int i = 0; i < N_SRC; i++)
        if (bus_addr_i == ADDR_W'(SRC_BASE + i)) rd_mux = src_rdata[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end
  assign bus_rdata_o = rdata_q;

  AST_SPUR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && bus_addr_i == ADDR_W'(ADR_ACK) && !int_o |=> bus_rdata_o == {{(DATA_W-VEC_W){1'b0}}, SPUR_VEC}); // R7
  AST_ONE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_sel)); // R6
  AST_RST_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_start |=> busy && tp_q == TPR_RST); // R10
  AST_TP_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> tp_q == TPR_RST && !mix_q); // R10
endmodule

// File: tb/tb_pic_top.sv
`timescale 1ns/1ps
module tb_pic_top;
  localparam int N = 20;
  localparam int GCR = 0, TPR = 1, ACK = 2, EOI = 3, SB = 32;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, d;
  logic [N-1:0] irq = '0;
  logic        int_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_top dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_rd_i(bus_rd), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_i(irq), .int_o(int_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 6'(a);
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); irq[i] = 1'b1;
    @(negedge clk); irq[i] = 1'b0;
  endtask

  function automatic logic [31:0] cw(input bit m, input bit p, input bit l, input int pr, input int v);
    return {m, 1'b0, 6'b0, p, l, 2'b0, pr[3:0], 8'b0, v[7:0]};
  endfunction

  initial begin
    #(4ns * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 int_o", 32'(int_o), 0);
    rd(SB, d);      chk("R1 src0", d, 32'h8080_0000);
    rd(SB + 19, d); chk("R1 src19", d, 32'h8080_0000);
    rd(TPR, d);     chk("R1 tpr", d, 32'hF);
    rd(ACK, d);     chk("R1 ack", d, 32'hFF);

    // sweep every line: R2 R3 R6 R8 R9
    wr(TPR, 0);
    for (int i = 0; i < N; i++) begin
      logic [31:0] w;
      w = cw(0, 1, 0, (i % 15) + 1, 8'h40 + i);
      wr(SB + i, w);
      rd(SB + i, d);  chk($sformatf("R2 readback %0d", i), d, w);
      pulse(i);
      chk($sformatf("R3 edge latched %0d", i), 32'(int_o), 1);
      rd(SB + i, d);  chk($sformatf("R9 active %0d", i), d, w | 32'h4000_0000);
      rd(ACK, d);     chk($sformatf("R6 vec %0d", i), d, 32'(8'h40 + i));
      chk($sformatf("R6 in service %0d", i), 32'(int_o), 0);
      wr(EOI, 0);
      rd(SB + i, d);  chk($sformatf("R8 retired %0d", i), d, w);
      wr(SB + i, 32'h8080_0000);
    end

    // R5 threshold sweep with a level line at priority 8
    wr(SB + 3, cw(0, 1, 1, 8, 8'h33));
    @(negedge clk); irq[3] = 1'b1;
    for (int t = 0; t < 16; t++) begin
      wr(TPR, 32'(t));
      chk($sformatf("R5 tp=%0d", t), 32'(int_o), (8 > t) ? 1 : 0);
    end
    wr(TPR, 0);
    // R4 level follows input
    @(negedge clk); irq[3] = 1'b0;
    @(negedge clk); chk("R4 level low", 32'(int_o), 0);
    irq[3] = 1'b1;
    @(negedge clk); chk("R4 level high", 32'(int_o), 1);
    rd(ACK, d);     chk("R6 level ack", d, 32'h33);
    chk("R4 level in service", 32'(int_o), 0);
    wr(EOI, 0);     chk("R8 level repends", 32'(int_o), 1);
    @(negedge clk); irq[3] = 1'b0;
    @(negedge clk); chk("R4 level drop", 32'(int_o), 0);
    wr(SB + 3, 32'h8080_0000);

    // R6 tie and order
    wr(SB + 5, cw(0, 1, 0, 6, 8'h55));
    wr(SB + 9, cw(0, 1, 0, 6, 8'h99));
    pulse(9); pulse(5);
    rd(ACK, d); chk("R6 tie low index", d, 32'h55);
    wr(EOI, 0);
    rd(ACK, d); chk("R6 tie second", d, 32'h99);
    wr(EOI, 0);
    chk("R6 tie drained", 32'(int_o), 0);

    // R12 nesting
    wr(SB + 1,  cw(0, 1, 0, 3, 8'h11));
    wr(SB + 2,  cw(0, 1, 0, 4, 8'h22));
    wr(SB + 10, cw(0, 1, 0, 12, 8'hAA));
    pulse(2);
    rd(ACK, d); chk("R12 first", d, 32'h22);
    pulse(1);
    chk("R12 lower blocked", 32'(int_o), 0);
    rd(ACK, d); chk("R7 lower spurious", d, 32'hFF);
    pulse(10);
    chk("R12 higher nests", 32'(int_o), 1);
    rd(ACK, d); chk("R12 nested vec", d, 32'hAA);
    wr(EOI, 0);
    rd(SB + 10, d); chk("R8 top retired", d[30], 0);
    rd(SB + 2, d);  chk("R8 lower still active", d[30], 1);
    chk("R12 still blocked", 32'(int_o), 0);
    wr(EOI, 0);
    chk("R12 released", 32'(int_o), 1);
    rd(ACK, d); chk("R12 waiting vec", d, 32'h11);
    wr(EOI, 0);

    // R9 lock while active
    wr(SB + 4, cw(0, 1, 0, 5, 8'h44));
    pulse(4);
    rd(ACK, d); chk("R9 ack", d, 32'h44);
    wr(SB + 4, cw(0, 1, 0, 9, 8'h77));
    rd(SB + 4, d); chk("R9 locked", d, cw(0, 1, 0, 5, 8'h44) | 32'h4000_0000);
    wr(SB + 4, cw(1, 0, 1, 9, 8'h77));
    rd(SB + 4, d); chk("R9 mask only", d, cw(1, 1, 0, 5, 8'h44) | 32'h4000_0000);
    wr(EOI, 0);
    rd(SB + 4, d); chk("R9 idle", d, cw(1, 1, 0, 5, 8'h44));

    // R7 mask after request, threshold raised
    wr(SB + 6, cw(0, 1, 0, 7, 8'h66));
    pulse(6);
    chk("R7 pending", 32'(int_o), 1);
    wr(SB + 6, cw(1, 1, 0, 7, 8'h66));
    chk("R7 masked", 32'(int_o), 0);
    rd(ACK, d); chk("R7 masked spurious", d, 32'hFF);
    wr(SB + 6, cw(0, 1, 0, 7, 8'h66));
    chk("R7 unmasked kept", 32'(int_o), 1);
    wr(TPR, 15);
    rd(ACK, d); chk("R7 tp spurious", d, 32'hFF);
    wr(TPR, 0);
    rd(ACK, d); chk("R7 recovered", d, 32'h66);
    wr(EOI, 0);

    // R3 falling edge, masked line ignores edges
    @(negedge clk); irq[7] = 1'b1;
    @(negedge clk); irq[7] = 1'b0;
    @(negedge clk); irq[7] = 1'b1;
    wr(SB + 7, cw(0, 0, 0, 9, 8'h77));
    chk("R3 masked edge ignored", 32'(int_o), 0);
    @(negedge clk); irq[7] = 1'b0;
    @(negedge clk); chk("R3 falling edge", 32'(int_o), 1);
    irq[7] = 1'b1;
    @(negedge clk); chk("R3 held", 32'(int_o), 1);
    rd(ACK, d); chk("R3 vec", d, 32'h77);
    wr(EOI, 0);
    chk("R3 drained", 32'(int_o), 0);

    // R11 mode bit, R10 command reset
    wr(GCR, 32'h2000_0000);
    rd(GCR, d); chk("R11 mode readback", d, 32'h2000_0000);
    wr(SB, cw(0, 1, 0, 5, 8'h01));
    wr(TPR, 2);
    wr(GCR, 32'h8000_0000);
    rd(GCR, d); chk("R10 busy", d, 32'h8000_0000);
    begin
      int n;
      n = 0;
      while (d[31] && n < 8) begin rd(GCR, d); n++; end
      chk("R10 busy clears", 32'(d[31]), 0);
    end
    chk("R11 mode cleared", d, 0);
    rd(TPR, d);    chk("R10 tpr", d, 32'hF);
    rd(SB, d);     chk("R10 src0", d, 32'h8080_0000);
    rd(SB + 7, d); chk("R10 src7", d, 32'h8080_0000);
    chk("R10 int_o", 32'(int_o), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule